// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This unit computes the quotient or remainder of two 32-bit integers, either signed or unsigned. It serves a 32-bit integer core and handles the four standard divide and remainder instructions. It works on one request at a time. A request enters through a ready / new-request handshake and carries both operands, a two-bit opcode and a destination tag. The result comes back through a done / accept handshake, together with the same tag.

Most requests run a restoring shift-and-subtract loop. The loop works on operand magnitudes and produces one quotient bit per cycle. The signs are applied in one final cycle. Three cases skip the loop and finish in two cycles:

- a zero divisor;
- the signed overflow case, where the most negative value is divided by minus one;
- a request whose dividend, divisor and signedness all match the last completed operation.

For the repeated case, the unit keeps both the quotient and the remainder of the last operation. A remainder that follows a divide on the same operands, or a divide that follows a remainder, is therefore answered at once.

Top module: `idiv_unit`

## Requirements
- R1: `issue_ready` is high after reset. It falls in the cycle after a request is accepted (`issue_new` and `issue_ready` both high at a clock edge). It stays low until the clock edge where `wb_accept` is seen with `wb_done` high. It is high in the cycle after that edge. At most one request is ever outstanding.
- R2: Once `wb_done` is high, it stays high, and `wb_result` and `wb_tag` hold their values, until the clock edge where `wb_accept` is high. After that edge, `wb_done` is low.
- R3: A zero divisor makes `wb_done` rise two cycles after acceptance. This holds for every opcode. The quotient is all ones and the remainder equals the dividend.
- R4: A signed request with dividend 0x80000000 and divisor 0xFFFFFFFF finishes two cycles after acceptance. The quotient is 0x80000000 and the remainder is 0.
- R5: A request whose dividend, divisor and signedness equal those of the last completed operation finishes two cycles after acceptance. It returns the stored quotient or remainder, whichever the opcode selects.
- R6: Every other request finishes 34 cycles after acceptance (32 loop cycles beyond the two-cycle minimum).
- R7: Signed results truncate toward zero. The remainder takes the sign of the dividend.
- R8: Unsigned requests treat both operands as values from 0 to 2^32-1.
- R9: Opcode bit 1 selects the remainder (1) or the quotient (0). Opcode bit 0 selects unsigned (1) or signed (0). So 00 is signed divide, 01 is unsigned divide, 10 is signed remainder and 11 is unsigned remainder.
- R10: `wb_tag` returns the tag that was presented with the request.
- R11: A request with the same operands as the last one but different signedness is not a repeat. It takes the full 34-cycle path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_ready | output | 1 | Unit can take a request |
| issue_new | input | 1 | Request present |
| issue_op | input | 2 | Bit 1: remainder; bit 0: unsigned |
| issue_a | input | XLEN | Dividend |
| issue_b | input | XLEN | Divisor |
| issue_tag | input | TAG_W | Destination tag |
| wb_done | output | 1 | Result valid |
| wb_accept | input | 1 | Writeback takes the result |
| wb_result | output | XLEN | Quotient or remainder |
| wb_tag | output | TAG_W | Tag of the result |

## Verification
The acceptance edge is cycle 0. `wb_done` is due after edge 2 for a zero divisor, for signed overflow and for a repeated operand set. It is due after edge 34 for everything else. `issue_ready` returns one edge after the accept edge.

A behavioural model in the bench sees the same edges. It counts edges since acceptance and picks the due edge from the operands. It compares `issue_ready`, `wb_done`, `wb_result` and `wb_tag` at every falling edge, away from the edges where values change. Writeback is held off for random stretches, so the hold rule is compared on each waiting cycle.

// File: rtl/idiv_unit.sv
module idiv_unit #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             issue_ready,
  input  logic             issue_new,
  input  logic [1:0]       issue_op,
  input  logic [XLEN-1:0]  issue_a,
  input  logic [XLEN-1:0]  issue_b,
  input  logic [TAG_W-1:0] issue_tag,
  output logic             wb_done,
  input  logic             wb_accept,
  output logic [XLEN-1:0]  wb_result,
  output logic [TAG_W-1:0] wb_tag
);
  localparam int CW = $clog2(XLEN);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_CLASS, S_ITER, S_FIX, S_DONE} st_t;
  st_t st;

  logic [XLEN-1:0]  a_r, b_r, bm, q_w, r_w;
  logic [XLEN-1:0]  lst_a, lst_b, lst_q, lst_r;
  logic             uns_r, rsel_r, fix_en, neg_q, neg_r, lst_v, lst_uns;
  logic [TAG_W-1:0] tag_r;
  logic [CW-1:0]    cnt;

  wire a_neg = !uns_r && a_r[XLEN-1];
  wire b_neg = !uns_r && b_r[XLEN-1];
  wire [XLEN-1:0] a_mag = a_neg ? -a_r : a_r;
  wire [XLEN-1:0] b_mag = b_neg ? -b_r : b_r;
  wire div0 = (b_r == '0);
  wire ovf  = !uns_r && (a_r == MOST_NEG) && (b_r == '1);
  wire hit  = lst_v && (lst_a == a_r) && (lst_b == b_r) && (lst_uns == uns_r);

  wire [XLEN:0] rem_sh = {r_w, q_w[XLEN-1]};
  wire [XLEN:0] diff   = rem_sh - {1'b0, bm};
  wire          ge     = !diff[XLEN];

  wire [XLEN-1:0] q_fin = (fix_en && neg_q) ? -q_w : q_w;
  wire [XLEN-1:0] r_fin = (fix_en && neg_r) ? -r_w : r_w;

  assign issue_ready = (st == S_IDLE);
  assign wb_done     = (st == S_DONE);
  assign wb_result   = rsel_r ? r_w : q_w;
  assign wb_tag      = tag_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lst_v   <= 1'b0;
      a_r     <= '0;
      b_r     <= '0;
      bm      <= '0;
      q_w     <= '0;
      r_w     <= '0;
      uns_r   <= 1'b0;
      rsel_r  <= 1'b0;
      tag_r   <= '0;
      cnt     <= '0;
      fix_en  <= 1'b0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      lst_a   <= '0;
      lst_b   <= '0;
      lst_q   <= '0;
      lst_r   <= '0;
      lst_uns <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (issue_new) begin
          a_r    <= issue_a;
          b_r    <= issue_b;
          uns_r  <= issue_op[0];
          rsel_r <= issue_op[1];
          tag_r  <= issue_tag;
          st     <= S_CLASS;
        end
        S_CLASS: begin
          fix_en <= 1'b0;
          st     <= S_FIX;
          if (hit) begin
            q_w <= lst_q;
            r_w <= lst_r;
          end else if (div0) begin
            q_w <= '1;
            r_w <= a_r;
          end else if (ovf) begin
            q_w <= a_r;
            r_w <= '0;
          end else begin
            q_w    <= a_mag;
            r_w    <= '0;
            bm     <= b_mag;
            cnt    <= '0;
            fix_en <= 1'b1;
            neg_q  <= a_neg ^ b_neg;
            neg_r  <= a_neg;
            st     <= S_ITER;
          end
        end
        S_ITER: begin
          q_w <= {q_w[XLEN-2:0], ge};
          r_w <= ge ? diff[XLEN-1:0] : rem_sh[XLEN-1:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(XLEN-1)) st <= S_FIX;
        end
        S_FIX: begin
          q_w     <= q_fin;
          r_w     <= r_fin;
          lst_q   <= q_fin;
          lst_r   <= r_fin;
          lst_a   <= a_r;
          lst_b   <= b_r;
          lst_uns <= uns_r;
          lst_v   <= 1'b1;
          st      <= S_DONE;
        end
        S_DONE: if (wb_accept) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idiv_unit_chk.sv
module idiv_unit_chk #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_ready,
  input logic             issue_new,
  input logic [1:0]       issue_op,
  input logic [XLEN-1:0]  issue_a,
  input logic [XLEN-1:0]  issue_b,
  input logic             wb_done,
  input logic             wb_accept,
  input logic [XLEN-1:0]  wb_result,
  input logic [TAG_W-1:0] wb_tag
);
  logic [7:0]      since;
  logic            cap_zero, cap_rem;
  logic [XLEN-1:0] cap_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since    <= 8'hff;
      cap_zero <= 1'b0;
      cap_rem  <= 1'b0;
      cap_a    <= '0;
    end else if (issue_new && issue_ready) begin
      since    <= 8'd0;
      cap_zero <= (issue_b == '0);
      cap_rem  <= issue_op[1];
      cap_a    <= issue_a;
    end else if (since != 8'hff) begin
      since <= since + 8'd1;
    end
  end

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_new && issue_ready) |=> !issue_ready);

  // R1
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |-> !issue_ready);

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && !wb_accept) |=> (wb_done && $stable(wb_result) && $stable(wb_tag)));

  // R3
  zero_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wb_done) && cap_zero) |-> (since == 8'd2));

  // R3
  zero_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && cap_zero) |-> (wb_result == (cap_rem ? cap_a : {XLEN{1'b1}})));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_done) |-> (since == 8'd2 || since == 8'(XLEN + 2)));
endmodule

bind idiv_unit idiv_unit_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_ready(issue_ready), .issue_new(issue_new),
  .issue_op(issue_op), .issue_a(issue_a), .issue_b(issue_b), .wb_done(wb_done),
  .wb_accept(wb_accept), .wb_result(wb_result), .wb_tag(wb_tag)
);

// File: tb/idiv_unit_test.sv
`timescale 1ns/1ps
module idiv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_new = 1'b0;
  logic [1:0]  issue_op = 2'd0;
  logic [31:0] issue_a = 32'd0, issue_b = 32'd0;
  logic [4:0]  issue_tag = 5'd0;
  logic        wb_accept = 1'b0;
  logic        issue_ready, wb_done;
  logic [31:0] wb_result;
  logic [4:0]  wb_tag;

  always #2 clk = ~clk;

  idiv_unit #(.XLEN(32), .TAG_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .issue_ready(issue_ready), .issue_new(issue_new),
    .issue_op(issue_op), .issue_a(issue_a), .issue_b(issue_b), .issue_tag(issue_tag),
    .wb_done(wb_done), .wb_accept(wb_accept), .wb_result(wb_result), .wb_tag(wb_tag)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_busy = 0, l_v = 0, l_uns = 0;
  int          m_cnt = 0, m_lat = 0;
  logic [31:0] m_res = 0, l_a = 0, l_b = 0;
  logic [4:0]  m_tag = 0;
  string       m_case = "R6", m_rcase = "R7";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0;
      l_v = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy && m_cnt >= m_lat && wb_accept) m_busy = 0;
      else if (m_busy) m_cnt++;
      if (!was_busy && issue_new) begin
        logic [31:0] q, r;
        bit uns, ovf, rep;
        uns = issue_op[0];
        ovf = !uns && issue_a == 32'h8000_0000 && issue_b == 32'hFFFF_FFFF;
        rep = l_v && l_a == issue_a && l_b == issue_b && l_uns == uns;
        if (issue_b == 0) begin q = '1; r = issue_a; end
        else if (ovf) begin q = issue_a; r = 0; end
        else if (!uns) begin
          q = $signed(issue_a) / $signed(issue_b);
          r = $signed(issue_a) % $signed(issue_b);
        end else begin
          q = issue_a / issue_b;
          r = issue_a % issue_b;
        end
        if (issue_b == 0) m_case = "R3";
        else if (ovf) m_case = "R4";
        else if (rep) m_case = "R5";
        else if (l_v && l_a == issue_a && l_b == issue_b) m_case = "R11";
        else m_case = "R6";
        m_rcase = (issue_b == 0) ? "R3" : ovf ? "R4" : uns ? "R8" : "R7";
        m_lat = (issue_b == 0 || ovf || rep) ? 2 : 34;
        m_res = issue_op[1] ? r : q;
        m_tag = issue_tag;
        m_cnt = 0;
        m_busy = 1;
        l_a = issue_a; l_b = issue_b; l_uns = uns; l_v = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_done;
      exp_done = m_busy && m_cnt >= m_lat;
      check(issue_ready == !m_busy, "R1 ready", {31'd0, issue_ready}, {31'd0, !m_busy});
      check(wb_done == exp_done, (m_busy && m_cnt > m_lat) ? "R2 done held" : {m_case, " done timing"},
            {31'd0, wb_done}, {31'd0, exp_done});
      if (exp_done && wb_done) begin
        check(wb_result == m_res, {m_rcase, " R9 result"}, wb_result, m_res);
        check(wb_tag == m_tag, "R10 tag", {27'd0, wb_tag}, {27'd0, m_tag});
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] tag, input int dly);
    @(negedge clk);
    while (!issue_ready) @(negedge clk);
    issue_new = 1'b1; issue_op = op; issue_a = a; issue_b = b; issue_tag = tag;
    @(posedge clk);
    #1 issue_new = 1'b0;
    @(negedge clk);
    while (!wb_done) @(negedge clk);
    repeat (dly) @(negedge clk);
    wb_accept = 1'b1;
    @(negedge clk);
    wb_accept = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(issue_ready == 1'b1, "R1 reset ready", {31'd0, issue_ready}, 32'd1);
    check(wb_done == 1'b0, "R2 reset done", {31'd0, wb_done}, 32'd0);

    run_op(2'b01, 32'd100, 32'd7, 5'd1, 0);                 // R8 divu
    run_op(2'b00, -32'sd100, 32'd7, 5'd2, 2);               // R7 div
    run_op(2'b10, -32'sd100, 32'd7, 5'd3, 0);               // R5 rem reuse
    run_op(2'b11, 32'hFFFF_FFF0, 32'd9, 5'd4, 1);           // R8 remu
    run_op(2'b10, 32'd77, -32'sd5, 5'd5, 0);                // R7 rem sign of dividend
    run_op(2'b00, 32'd123, 32'd0, 5'd6, 3);                 // R3 div by zero
    run_op(2'b11, 32'hDEAD_BEEF, 32'd0, 5'd7, 0);           // R3 remu by zero
    run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 5'd8, 0);   // R4 overflow div
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 5'd9, 1);   // R4 overflow rem
    run_op(2'b01, 32'h8000_0000, 32'hFFFF_FFFF, 5'd10, 0);  // R11 unsigned, full path
    run_op(2'b00, 32'd1000, 32'd33, 5'd11, 0);              // R6
    run_op(2'b10, 32'd1000, 32'd33, 5'd12, 0);              // R5
    run_op(2'b11, 32'd1000, 32'd33, 5'd13, 0);              // R11
    run_op(2'b10, 32'd1000, 32'd33, 5'd14, 4);              // R11 back to signed

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      int sel;
      sel = $urandom % 6;
      a = $urandom;
      b = (sel == 0) ? 32'd0 : (sel == 1) ? ($urandom % 16) + 1 : $urandom;
      if (sel == 2) begin a = l_a; b = l_b; end
      run_op(2'($urandom % 4), a, b, 5'($urandom), $urandom % 3);
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule